// File: doc/BRIEF.md
# Vector Right Shift by Immediate Unit

This block decodes one SIMD right-shift-by-immediate instruction word and executes it on every lane of a 128-bit source vector in the same pass. It supports five operation kinds, each signed or unsigned: a plain shift, a shift whose result is added to the destination, a rounding shift, a rounding shift whose result is added to the destination, and a shift-right-insert that merges the shifted source under the upper bits of the old destination lane. Lanes are 8, 16, 32 or 64 bits wide. A 7-bit packed immediate sets both the lane width and the shift count.

The caller presents the instruction word, the source vector and the old destination vector with a valid strobe. One clock later the unit returns the result, a valid strobe and a flag that marks words which are not legal encodings of this instruction class. Register-file access lies outside the block. The caller writes the result back to the register file, or raises an exception when the flag is set.

Top module: `vshr_imm_unit`

## Requirements
- R1: A word is legal only if bit 31 is 0, bits 28:23 equal 011110 and bit 10 is 1. Any other word sets out_illegal.
- R2: The lane width comes from the highest set bit of the 4-bit field in bits 22:19: bit 19 gives 8, bit 20 gives 16, bit 21 gives 32 and bit 22 gives 64. The shift count is twice the lane width minus the 7-bit value in bits 22:16, which gives a range of 1 to the lane width. Legal words clear out_illegal.
- R3: A word whose bits 22:19 are all zero sets out_illegal.
- R4: A 64-bit lane width together with bit 30 (full width) at 0 sets out_illegal.
- R5: The operation field in bits 15:11 accepts 00000 (shift), 00010 (shift and accumulate), 00100 (rounding shift), 00110 (rounding shift and accumulate) and 01000 (insert). Insert also needs bit 29 at 1. Every other value sets out_illegal.
- R6: Bit 29 at 1 gives a logical shift and bit 29 at 0 gives an arithmetic shift. When the count equals the lane width, the result is 0 (logical) or a copy of the sign bit in every position (arithmetic).
- R7: A rounding shift adds 2^(count-1) to the lane before shifting, with no loss of the carry.
- R8: The accumulate forms add the shifted lane to the matching destination lane, modulo 2^width.
- R9: Insert keeps the top `count` bits of the destination lane and fills the low bits with the logically shifted source lane. When the count equals the width, the destination lane is unchanged.
- R10: When bit 30 is 0, result bits 127:64 are zero.
- R11: out_valid is in_valid delayed by one clock. out_result and out_illegal load only on a cycle with in_valid high, and they hold otherwise.
- R12: When out_illegal is 1, out_result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Old destination vector |
| out_valid | output | 1 | Result present |
| out_result | output | 128 | Result vector |
| out_illegal | output | 1 | Word is not a legal encoding |

## Verification
The assertions take for granted that in_valid is never unknown after reset, and that insn carries known bit values in every cycle where in_valid is high. They also assume that nothing drives the outputs other than the unit's own registers. The stimulus meets these conditions by driving every input to a defined value on the falling edge from reset onward. It drops in_valid between phases and never leaves an operand field undriven. The main sweep covers every lane width, every count and both vector widths for each legal operation and sign. Illegal words are applied only as whole, fully specified words.

// File: rtl/vshr_pkg.sv
package vshr_pkg;

  localparam int unsigned INSN_W   = 32;
  localparam int unsigned MAX_LANE = 64;
  localparam int unsigned CNT_W    = $clog2(MAX_LANE) + 1;
  localparam int unsigned NUM_ESZ  = 4;

  localparam logic [5:0] CLASS_TAG = 6'b011110;

  typedef enum logic [4:0] {
    OP_SHR  = 5'b00000,
    OP_ACC  = 5'b00010,
    OP_RSHR = 5'b00100,
    OP_RACC = 5'b00110,
    OP_INS  = 5'b01000
  } vshr_op_e;

  typedef struct packed {
    logic             legal;
    logic             full;
    logic [1:0]       esz;
    logic [CNT_W-1:0] count;
    logic             arith;
    logic             do_round;
    logic             do_acc;
    logic             do_ins;
  } vshr_dec_t;

endpackage

// File: rtl/vshr_decode.sv
module vshr_decode
  import vshr_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output vshr_dec_t         dec_o
);

  logic [3:0] lw_sel;
  logic [6:0] packed_imm;
  logic [4:0] op_field;
  logic       unsigned_bit;
  logic       full_bit;
  logic [1:0] esz;
  logic [7:0] twice_width;
  logic [7:0] count_wide;
  logic       fmt_ok;
  logic       op_ok;

  assign lw_sel       = insn_i[22:19];
  assign packed_imm   = insn_i[22:16];
  assign op_field     = insn_i[15:11];
  assign unsigned_bit = insn_i[29];
  assign full_bit     = insn_i[30];

  // leading-one pick of the lane size
  always_comb begin
    casez (lw_sel)
      4'b1???: esz = 2'd3;
      4'b01??: esz = 2'd2;
      4'b001?: esz = 2'd1;
      default: esz = 2'd0;
    endcase
  end

  assign twice_width = 8'd16 << esz;
  assign count_wide  = twice_width - {1'b0, packed_imm};

  assign fmt_ok = ~insn_i[31] && (insn_i[28:23] == CLASS_TAG) && insn_i[10]
                  && (lw_sel != 4'b0000) && !((esz == 2'd3) && !full_bit);

  always_comb begin
    op_ok = 1'b0;
    case (op_field)
      OP_SHR, OP_ACC, OP_RSHR, OP_RACC: op_ok = 1'b1;
      OP_INS:                           op_ok = unsigned_bit;
      default:                          op_ok = 1'b0;
    endcase
  end

  always_comb begin
    dec_o          = '0;
    dec_o.legal    = fmt_ok && op_ok;
    dec_o.full     = full_bit;
    dec_o.esz      = esz;
    dec_o.count    = count_wide[CNT_W-1:0];
    dec_o.arith    = ~unsigned_bit;
    dec_o.do_round = (op_field == OP_RSHR) || (op_field == OP_RACC);
    dec_o.do_acc   = (op_field == OP_ACC)  || (op_field == OP_RACC);
    dec_o.do_ins   = (op_field == OP_INS);
  end

endmodule

// File: rtl/vshr_lane.sv
module vshr_lane #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 7
) (
  input  logic [W-1:0]     src_i,
  input  logic [W-1:0]     dst_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             arith_i,
  input  logic             round_i,
  input  logic             acc_i,
  input  logic             ins_i,
  output logic [W-1:0]     res_o
);

  localparam int unsigned      EW    = W + 2;
  localparam logic [CNT_W-1:0] W_CNT = CNT_W'(W);

  logic [EW-1:0] ext_val;
  logic [EW-1:0] bias;
  logic [EW-1:0] biased;
  logic [EW-1:0] shifted;
  logic [W-1:0]  shv;
  logic [W-1:0]  low_mask;

  // two guard bits: one for sign/zero fill, one for the rounding carry
  assign ext_val = {{2{arith_i & src_i[W-1]}}, src_i};
  assign bias    = round_i ? (EW'(1) << (count_i - 1'b1)) : '0;
  assign biased  = ext_val + bias;
  assign shifted = $signed(biased) >>> count_i;
  assign shv     = shifted[W-1:0];

  assign low_mask = (count_i >= W_CNT) ? '0
                  : ((W'(1) << (W_CNT - count_i)) - W'(1));

  always_comb begin
    if (ins_i) begin
      res_o = (dst_i & ~low_mask) | (shv & low_mask);
    end else if (acc_i) begin
      res_o = dst_i + shv;
    end else begin
      res_o = shv;
    end
  end

endmodule

// File: rtl/vshr_lane_bank.sv
module vshr_lane_bank #(
  parameter int unsigned W     = 8,
  parameter int unsigned VEC_W = 128,
  parameter int unsigned CNT_W = 7
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             arith_i,
  input  logic             round_i,
  input  logic             acc_i,
  input  logic             ins_i,
  output logic [VEC_W-1:0] res_o
);

  localparam int unsigned LANES = VEC_W / W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vshr_lane #(
      .W     (W),
      .CNT_W (CNT_W)
    ) lane_i (
      .src_i   (src_i[l*W +: W]),
      .dst_i   (dst_i[l*W +: W]),
      .count_i (count_i),
      .arith_i (arith_i),
      .round_i (round_i),
      .acc_i   (acc_i),
      .ins_i   (ins_i),
      .res_o   (res_o[l*W +: W])
    );
  end

endmodule

// File: rtl/vshr_imm_unit.sv
module vshr_imm_unit
  import vshr_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [VEC_W-1:0]  dst_vec,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_result,
  output logic              out_illegal
);

  localparam int unsigned HALF_W = VEC_W / 2;

  vshr_dec_t dec;
  logic [NUM_ESZ-1:0][VEC_W-1:0] bank_res;
  logic [VEC_W-1:0] sel_res;
  logic [VEC_W-1:0] res_d;
  logic             ill_d;
  logic [VEC_W-1:0] res_q;
  logic             ill_q;
  logic             vld_q;

  vshr_decode dec_i (
    .insn_i (insn),
    .dec_o  (dec)
  );

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_bank
    vshr_lane_bank #(
      .W     (8 << g),
      .VEC_W (VEC_W),
      .CNT_W (CNT_W)
    ) bank_i (
      .src_i   (src_vec),
      .dst_i   (dst_vec),
      .count_i (dec.count),
      .arith_i (dec.arith & ~dec.do_ins),
      .round_i (dec.do_round),
      .acc_i   (dec.do_acc),
      .ins_i   (dec.do_ins),
      .res_o   (bank_res[g])
    );
  end

  assign sel_res = bank_res[dec.esz];

  // next-state
  always_comb begin
    ill_d = ~dec.legal;
    res_d = '0;
    if (dec.legal) begin
      res_d = sel_res;
      if (!dec.full) begin
        res_d[VEC_W-1:HALF_W] = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        ill_q <= ill_d;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_result  = res_q;
  assign out_illegal = ill_q;

endmodule

// File: rtl/vshr_imm_unit_chk.sv
module vshr_imm_unit_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      insn,
  input logic [VEC_W-1:0] src_vec,
  input logic [VEC_W-1:0] dst_vec,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_result,
  input logic             out_illegal
);

  localparam int unsigned HALF_W = VEC_W / 2;

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_illegal)));

  a_r12_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !insn[30]) |=> (out_result[VEC_W-1:HALF_W] == '0));

  a_r3_immh_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (insn[22:19] == 4'b0000)) |=> out_illegal);

  a_r4_wide_half: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[22] && !insn[30]) |=> out_illegal);

  a_r5_insert_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (insn[15:11] == 5'b01000) && !insn[29]) |=> out_illegal);

  a_r1_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (insn[31] || !insn[10])) |=> out_illegal);

endmodule

bind vshr_imm_unit vshr_imm_unit_chk #(.VEC_W(VEC_W)) chk_i (.*);

// File: tb/vshr_imm_unit_tb_top.sv
`timescale 1ns/1ps
module vshr_imm_unit_tb_top;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  insn;
  logic [127:0] src_vec;
  logic [127:0] dst_vec;
  logic         out_valid;
  logic [127:0] out_result;
  logic         out_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  vshr_imm_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .insn        (insn),
    .src_vec     (src_vec),
    .dst_vec     (dst_vec),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit q, input bit u, input logic [6:0] hb,
                                     input logic [4:0] op);
    return {1'b0, q, u, 6'b011110, hb, op, 1'b1, 5'd3, 5'd7};
  endfunction

  function automatic logic [127:0] ref_result(input logic [31:0] w, input logic [127:0] s,
                                              input logic [127:0] d, output bit ill);
    int esz, lw, cnt, nl;
    logic [4:0] op;
    logic [127:0] res, lm, sl, dl, r, km;
    logic signed [129:0] a;
    bit q, u;
    q = w[30]; u = w[29]; op = w[15:11];
    if (w[22]) esz = 3; else if (w[21]) esz = 2; else if (w[20]) esz = 1; else esz = 0;
    ill = 0;
    if (w[31] || w[28:23] != 6'b011110 || !w[10] || w[22:19] == 4'b0) ill = 1;
    if (esz == 3 && !q) ill = 1;
    if (!(op inside {5'b00000, 5'b00010, 5'b00100, 5'b00110, 5'b01000})) ill = 1;
    if (op == 5'b01000 && !u) ill = 1;
    if (ill) return '0;
    lw  = 8 << esz;
    cnt = 2 * lw - int'(w[22:16]);
    nl  = (q ? 128 : 64) / lw;
    lm  = (128'd1 << lw) - 128'd1;
    res = '0;
    for (int i = 0; i < nl; i++) begin
      sl = (s >> (i * lw)) & lm;
      dl = (d >> (i * lw)) & lm;
      a  = $signed({2'b00, sl});
      if (!u && sl[lw-1]) a = a - ($signed(130'd1) <<< lw);
      if (op == 5'b00100 || op == 5'b00110) a = a + ($signed(130'd1) <<< (cnt - 1));
      a = a >>> cnt;
      r = a[127:0] & lm;
      if (op == 5'b00010 || op == 5'b00110) r = (r + dl) & lm;
      if (op == 5'b01000) begin
        km = lm & ~((128'd1 << (lw - cnt)) - 128'd1);
        r  = (dl & km) | (r & ~km);
      end
      res = res | (r << (i * lw));
    end
    return res;
  endfunction

  // drive one word for one cycle, then sample after the registering edge
  task automatic apply(input logic [31:0] w, input logic [127:0] s, input logic [127:0] d,
                       input string req);
    logic [127:0] exp;
    bit ill;
    exp = ref_result(w, s, d, ill);
    insn = w; src_vec = s; dst_vec = d; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", {127'd0, out_valid}, 128'd1);
    check(ill ? "R12" : req, out_result, exp);
    check(ill ? req : "R2", {127'd0, out_illegal}, {127'd0, ill});
    if (!w[30]) check("R10", {64'd0, out_result[127:64]}, 128'd0);
  endtask

  function automatic string op_tag(input logic [4:0] op);
    case (op)
      5'b00010, 5'b00110: return "R8";
      5'b00100:           return "R7";
      5'b01000:           return "R9";
      default:            return "R6";
    endcase
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog act=%0d exp<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [4:0] ops [5];
    logic [127:0] s, d, held;
    ops[0] = 5'b00000; ops[1] = 5'b00010; ops[2] = 5'b00100;
    ops[3] = 5'b00110; ops[4] = 5'b01000;
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; src_vec = '0; dst_vec = '0;
    repeat (3) @(negedge clk);
    check("R11", {126'd0, out_valid, out_illegal}, 128'd0);
    check("R11", out_result, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: every width, count, half/full, sign, operation
    for (int esz = 0; esz < 4; esz++) begin
      for (int cnt = 1; cnt <= (8 << esz); cnt++) begin
        for (int qi = 0; qi < 2; qi++) begin
          for (int ui = 0; ui < 2; ui++) begin
            for (int oi = 0; oi < 5; oi++) begin
              logic [6:0] hb;
              if (esz == 3 && qi == 0) continue;
              if (oi == 4 && ui == 0) continue;
              hb = 7'(2 * (8 << esz) - cnt);
              case (cnt % 3)
                0: begin s = {128{1'b1}}; d = rnd128(); end
                1: begin s = {16{8'h80}} ^ rnd128() & {16{8'h0f}}; d = {128{1'b1}}; end
                default: begin s = rnd128(); d = rnd128(); end
              endcase
              apply(mk(qi[0], ui[0], hb, ops[oi]), s, d, op_tag(ops[oi]));
            end
          end
        end
      end
    end

    // R6 corner: count == width, fixed data
    apply(mk(1'b1, 1'b0, 7'h40, 5'b00000), {2{64'h8000_0000_0000_0001}}, '0, "R6");
    apply(mk(1'b1, 1'b1, 7'h40, 5'b00000), {2{64'h8000_0000_0000_0001}}, '0, "R6");
    // R7 rounding carry: 0xFF >> 1 unsigned -> 0x80
    apply(mk(1'b1, 1'b1, 7'h0f, 5'b00100), {16{8'hff}}, '0, "R7");

    // illegal encodings
    apply(mk(1'b1, 1'b1, 7'h05, 5'b00000), rnd128(), rnd128(), "R3");
    apply(mk(1'b0, 1'b1, 7'h50, 5'b00000), rnd128(), rnd128(), "R4");
    apply(mk(1'b1, 1'b0, 7'h10, 5'b01000), rnd128(), rnd128(), "R5");
    apply(mk(1'b1, 1'b1, 7'h10, 5'b00001), rnd128(), rnd128(), "R5");
    apply(mk(1'b1, 1'b1, 7'h10, 5'b01010), rnd128(), rnd128(), "R5");
    apply(mk(1'b1, 1'b1, 7'h10, 5'b00000) | 32'h8000_0000, rnd128(), rnd128(), "R1");
    apply(mk(1'b1, 1'b1, 7'h10, 5'b00000) & ~32'h0000_0400, rnd128(), rnd128(), "R1");
    apply(mk(1'b1, 1'b1, 7'h10, 5'b00000) ^ 32'h0100_0000, rnd128(), rnd128(), "R1");

    // R11 hold: inputs move with in_valid low, outputs keep
    apply(mk(1'b1, 1'b1, 7'h0c, 5'b00000), rnd128(), rnd128(), "R6");
    held = out_result;
    insn = mk(1'b1, 1'b0, 7'h0a, 5'b00010); src_vec = rnd128(); dst_vec = rnd128();
    @(negedge clk);
    check("R11", {127'd0, out_valid}, 128'd0);
    check("R11", out_result, held);
    check("R11", {127'd0, out_illegal}, 128'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule